// File: doc/BRIEF.md
# FIFO-Buffered SPI Master Controller

This block is a register-mapped SPI master. Software configures polarity, phase, word length and bit rate through a configuration register. It then queues outgoing words through a single data port and starts the shift engine with a command bit. Each queued word can carry an end-of-transfer flag. When the flagged word has been shifted, the engine stops the bit clock at its idle level and raises a completion event. Every received word goes into a receive queue, and software pops it through the same data port.

Faults are reported as events with write-one-to-clear bits: the transmit queue running dry in the middle of a transfer, the receive queue being full when a word completes, and another master pulling the shared select line. The events also include queue-level requests whose thresholds software can set. A per-bit mask combines the event bits into one level-sensitive interrupt line.

Top module: `spim_ctrl`

## Requirements
- R1: The bit-clock half period is 2*(rate+1) clock cycles, where rate is CONFIG[9:4] (6 bits, 0..63).
- R2: CONFIG[2] sets the idle level of sclk. CONFIG[3]=0 makes both sides sample on the edge leaving idle and change data on the returning edge. CONFIG[3]=1 makes both sides change data on the leaving edge and sample on the returning edge. Data goes out MSB first.
- R3: CONFIG[12:10] holds word length minus one. Only the low length bits of a written word are sent, and received words are right-aligned in the low bits.
- R4: A word written to DATA (address 5) with bit 8 set ends the transfer. After its last edge, EVENT[0] (done) is set and sclk rests at its idle level.
- R5: CONTROL (address 1) is write-only and reads 0. Bit 0 empties the receive queue, bit 1 empties the transmit queue, and bit 2 starts shifting. Start has no effect while CONFIG[0] (enable) is 0.
- R6: STATUS (address 2) bits are: [0] ready, set one cycle after enable; [1] transmit queue full; [2] receive queue empty; [3] interrupt pending. The reset value is 4'b0100.
- R7: EVENT (address 3) bits stay set until a 1 is written to them. Writing 0 leaves them unchanged, and a new event in the same cycle wins over a clear.
- R8: When the engine needs another word before the flagged word has gone and the transmit queue is empty, EVENT[2] is set. The engine then holds sclk idle until a word arrives, and the transfer resumes.
- R9: When a word completes while the 8-entry receive queue is full, EVENT[1] is set and that word is dropped. The earlier contents are kept.
- R10: ss_in_n low while enabled sets EVENT[3] and aborts shifting, returning sclk to idle.
- R11: EVENT[4] is set while enabled and transmit free space is at least CONFIG[15:13]+1. EVENT[5] is set while receive occupancy is at least CONFIG[18:16]+1.
- R12: irq is high when any EVENT bit is set whose MASK (address 4) bit is 0. MASK resets to all ones.
- R13: A DATA write pushes the transmit queue and is ignored when the queue is full. A DATA read pops the receive queue and returns the word in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| sclk | output | 1 | SPI bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_in_n | input | 1 | Shared select line, low when another master drives it |
| irq | output | 1 | Level interrupt |

## Verification
A behavioural slave on the serial pins exchanges known byte streams with the block in all four clock modes and at several rates. This separates errors of polarity from errors of sampling phase, and checks the edge spacing against the rate field. A 4-bit word length shows whether words are truncated and right-aligned correctly. Transfers are also run that starve the transmit queue, overfill the receive queue and pull the select line mid-word, which shows that each fault raises only its own event. A final set of patterns covers pushing into a full queue, starting while disabled, and crossing the threshold levels.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int WORD_W = 8;
    localparam int LEN_W  = $clog2(WORD_W);
    localparam int RATE_W = 6;
    localparam int THR_W  = 3;

    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_EVT  = 3'd3;
    localparam logic [2:0] A_MASK = 3'd4;
    localparam logic [2:0] A_DATA = 3'd5;

    localparam int EV_DONE = 0;
    localparam int EV_RXOV = 1;
    localparam int EV_TXUN = 2;
    localparam int EV_MULT = 3;
    localparam int EV_TXRQ = 4;
    localparam int EV_RXRQ = 5;
    localparam int EV_W    = 6;

    localparam int LAST_BIT = 8;

    typedef struct packed {
        logic [THR_W-1:0]  rx_thr_m1;
        logic [THR_W-1:0]  tx_thr_m1;
        logic [LEN_W-1:0]  len_m1;
        logic [RATE_W-1:0] rate;
        logic              cpha;
        logic              cpol;
        logic              dma_off;
        logic              enable;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_FETCH = 2'd1,
        SH_RUN   = 2'd2
    } sh_state_e;

    function automatic logic [WORD_W-1:0] word_mask(input logic [LEN_W-1:0] len_m1);
        return {WORD_W{1'b1}} >> (WORD_W - 1 - int'(len_m1));
    endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assert_fifo_bound_R13: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    assert_full_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> full);
endmodule

// File: rtl/spim_divider.sv
module spim_divider #(
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [RW-1:0] rate,
    output logic          tick
);
    localparam int CW = RW + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = {rate, 1'b1};
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [RATE_W-1:0] rate,
    input  logic              start,
    input  logic              abort,
    input  logic              tx_avail,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_last,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              done,
    output logic              under,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam int EW = LEN_W + 1;

    sh_state_e         state;
    logic [WORD_W-1:0] sreg, rx_q, rx_next;
    logic [EW-1:0]     edge_q, last_edge;
    logic              cur_last, starved, sclk_r, tick;
    logic              sample_now, shift_now, word_end;

    spim_divider #(.RW(RATE_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (state == SH_RUN),
        .rate (rate),
        .tick (tick)
    );

    always_comb begin
        last_edge  = {len_m1, 1'b1};
        sample_now = tick && (cpha ? edge_q[0] : !edge_q[0]);
        shift_now  = tick && (cpha ? (!edge_q[0] && edge_q != '0) : edge_q[0]);
        rx_next    = sample_now ? {rx_q[WORD_W-2:0], miso} : rx_q;
        word_end   = (state == SH_RUN) && tick && (edge_q == last_edge);
    end

    assign rx_push = word_end && !abort;
    assign rx_word = rx_next & word_mask(len_m1);
    assign done    = word_end && cur_last && !abort;
    assign tx_pop  = (state == SH_FETCH) && tx_avail && !abort;
    assign under   = (state == SH_FETCH) && !tx_avail && !starved && !abort;
    assign busy    = (state != SH_IDLE);
    assign sclk    = sclk_r;
    assign mosi    = sreg[len_m1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SH_IDLE;
            sreg     <= '0;
            rx_q     <= '0;
            edge_q   <= '0;
            cur_last <= 1'b0;
            starved  <= 1'b0;
            sclk_r   <= 1'b0;
        end else if (abort) begin
            state  <= SH_IDLE;
            sclk_r <= cpol;
        end else begin
            case (state)
                SH_IDLE: begin
                    sclk_r <= cpol;
                    if (start) begin
                        state   <= SH_FETCH;
                        starved <= 1'b0;
                    end
                end
                SH_FETCH: begin
                    if (tx_avail) begin
                        sreg     <= tx_data;
                        cur_last <= tx_last;
                        edge_q   <= '0;
                        rx_q     <= '0;
                        starved  <= 1'b0;
                        sclk_r   <= cpol;
                        state    <= SH_RUN;
                    end else if (under) begin
                        starved <= 1'b1;
                    end
                end
                SH_RUN: begin
                    if (tick) begin
                        sclk_r <= ~sclk_r;
                        rx_q   <= rx_next;
                        if (shift_now) sreg <= sreg << 1;
                        if (word_end) state <= cur_last ? SH_IDLE : SH_FETCH;
                        else          edge_q <= edge_q + EW'(1);
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    assert_idle_level_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SH_IDLE && $past(state) == SH_IDLE && $stable(cpol) && !$past(rst))
            |-> sclk == cpol);

    assert_sclk_only_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
        (state == SH_RUN && !tick && !abort) |=> $stable(sclk));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    input  logic        ss_in_n,
    output logic        irq
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    cfg_t              cfg_q;
    logic [EV_W-1:0]   ev_q, ev_set, mask_q;
    logic              ready_q;

    logic wr_cfg, wr_ctrl, wr_evt, wr_mask, wr_data, rd_data;
    logic start_cmd, mm_hit, abort;

    logic [WORD_W:0]   txf_dout;
    logic [CW-1:0]     txf_cnt, rxf_cnt, tx_free, tx_thr, rx_thr;
    logic              txf_full, txf_empty, txf_pop;
    logic [WORD_W-1:0] rxf_dout, sh_rx_word;
    logic              rxf_full, rxf_empty;
    logic              sh_rx_push, sh_done, sh_under, sh_busy;

    always_comb begin
        wr_cfg  = bus_sel && bus_wr && (bus_addr == A_CFG);
        wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
        wr_evt  = bus_sel && bus_wr && (bus_addr == A_EVT);
        wr_mask = bus_sel && bus_wr && (bus_addr == A_MASK);
        wr_data = bus_sel && bus_wr && (bus_addr == A_DATA);
        rd_data = bus_sel && !bus_wr && (bus_addr == A_DATA);
        start_cmd = wr_ctrl && bus_wdata[2] && cfg_q.enable;
        mm_hit    = cfg_q.enable && !ss_in_n;
        abort     = !cfg_q.enable || mm_hit;
        tx_free   = CW'(FIFO_DEPTH) - txf_cnt;
        tx_thr    = CW'(cfg_q.tx_thr_m1) + CW'(1);
        rx_thr    = CW'(cfg_q.rx_thr_m1) + CW'(1);
        ev_set = '0;
        ev_set[EV_DONE] = sh_done;
        ev_set[EV_RXOV] = sh_rx_push && rxf_full;
        ev_set[EV_TXUN] = sh_under;
        ev_set[EV_MULT] = mm_hit;
        ev_set[EV_TXRQ] = cfg_q.enable && (tx_free >= tx_thr);
        ev_set[EV_RXRQ] = (rxf_cnt >= rx_thr);
    end

    assign irq = |(ev_q & ~mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            ev_q    <= '0;
            mask_q  <= '1;
            ready_q <= 1'b0;
        end else begin
            if (wr_cfg)  cfg_q  <= cfg_t'(bus_wdata[CFG_W-1:0]);
            if (wr_mask) mask_q <= bus_wdata[EV_W-1:0];
            ev_q    <= (ev_q & ~(wr_evt ? bus_wdata[EV_W-1:0] : '0)) | ev_set;
            ready_q <= cfg_q.enable;
        end
    end

    spim_fifo #(.W(WORD_W + 1), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk   (clk),
        .rst   (rst),
        .clr   (wr_ctrl && bus_wdata[1]),
        .push  (wr_data),
        .pop   (txf_pop),
        .din   ({bus_wdata[LAST_BIT], bus_wdata[WORD_W-1:0]}),
        .dout  (txf_dout),
        .count (txf_cnt),
        .full  (txf_full),
        .empty (txf_empty)
    );

    spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk   (clk),
        .rst   (rst),
        .clr   (wr_ctrl && bus_wdata[0]),
        .push  (sh_rx_push),
        .pop   (rd_data),
        .din   (sh_rx_word),
        .dout  (rxf_dout),
        .count (rxf_cnt),
        .full  (rxf_full),
        .empty (rxf_empty)
    );

    spim_shifter u_sh (
        .clk      (clk),
        .rst      (rst),
        .cpol     (cfg_q.cpol),
        .cpha     (cfg_q.cpha),
        .len_m1   (cfg_q.len_m1),
        .rate     (cfg_q.rate),
        .start    (start_cmd),
        .abort    (abort),
        .tx_avail (!txf_empty),
        .tx_data  (txf_dout[WORD_W-1:0]),
        .tx_last  (txf_dout[WORD_W]),
        .tx_pop   (txf_pop),
        .rx_push  (sh_rx_push),
        .rx_word  (sh_rx_word),
        .done     (sh_done),
        .under    (sh_under),
        .busy     (sh_busy),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso)
    );

    always_comb begin
        case (bus_addr)
            A_CFG:   bus_rdata = 32'(cfg_q);
            A_STAT:  bus_rdata = {28'd0, irq, rxf_empty, txf_full, ready_q};
            A_EVT:   bus_rdata = 32'(ev_q);
            A_MASK:  bus_rdata = 32'(mask_q);
            A_DATA:  bus_rdata = rxf_empty ? 32'd0 : 32'(rxf_dout);
            default: bus_rdata = 32'd0;
        endcase
    end

    assert_done_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_evt && bus_wdata[EV_DONE] && !sh_done) |=> !ev_q[EV_DONE]);

    assert_mm_abort_R10: assert property (@(posedge clk) disable iff (rst)
        mm_hit |=> !sh_busy);

    assert_overflow_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (sh_rx_push && rxf_full) |=> ev_q[EV_RXOV]);

    assert_no_pop_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!sh_busy) |-> !txf_pop);
endmodule

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso, irq;
    logic        ss_in_n = 1'b1;

    int checks = 0;
    int fails  = 0;

    int b_cpol = 0, b_cpha = 0, b_nbits = 8, b_rate = 0;
    logic sl_load = 1'b0;

    logic [7:0] resp [16];
    logic [7:0] cap  [16];
    logic [7:0] sl_tx = 8'd0, sl_rx = 8'd0;
    int cap_n = 0, wi = 0, e = 0;
    int cyc = 0, last_chg = 0, last_half = 0;
    logic sclk_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spim_ctrl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_in_n(ss_in_n), .irq(irq)
    );

    assign miso = sl_tx[b_nbits-1];

    function automatic logic [7:0] txv(input int i);
        return 8'(8'h5A + i * 29);
    endfunction

    function automatic logic [7:0] wmask();
        return 8'((1 << b_nbits) - 1);
    endfunction

    // behavioural SPI slave, evaluated away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sl_load) begin
            e = 0; cap_n = 0; wi = 0; sl_tx = resp[0]; sl_rx = 8'd0;
            last_chg = cyc;
        end else if (sclk !== sclk_prev) begin
            last_half = cyc - last_chg;
            last_chg  = cyc;
            if (sclk != 1'(b_cpol)) begin
                if (b_cpha == 0) sl_rx = {sl_rx[6:0], mosi};
                else if (e != 0) sl_tx = sl_tx << 1;
            end else begin
                if (b_cpha == 0) sl_tx = sl_tx << 1;
                else             sl_rx = {sl_rx[6:0], mosi};
            end
            e = e + 1;
            if (e == 2 * b_nbits) begin
                if (cap_n < 16) cap[cap_n] = sl_rx & wmask();
                cap_n = cap_n + 1;
                wi = (wi < 15) ? wi + 1 : 15;
                sl_tx = resp[wi];
                e = 0;
            end
        end
        sclk_prev = sclk;
    end

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic slave_reload();
        @(posedge clk); #1 sl_load = 1'b1;
        @(posedge clk); #1 sl_load = 1'b0;
    endtask

    task automatic set_cfg(input int en, input int cpol, input int cpha, input int rate,
                           input int len_m1, input int txt, input int rxt);
        bus_write(3'd0, 32'(en | (1 << 1) | (cpol << 2) | (cpha << 3) | (rate << 4) |
                            (len_m1 << 10) | (txt << 13) | (rxt << 16)));
        b_cpol = cpol; b_cpha = cpha; b_rate = rate; b_nbits = len_m1 + 1;
        repeat (4) @(negedge clk);
        slave_reload();
    endtask

    task automatic clear_all();
        bus_write(3'd1, 32'h3);
        bus_write(3'd3, 32'h3F);
    endtask

    task automatic wait_ev(input int bitn, output bit ok);
        logic [31:0] d;
        ok = 1'b0;
        for (int k = 0; k < 3000 && !ok; k++) begin
            bus_read(3'd3, d);
            if (d[bitn]) ok = 1'b1;
        end
    endtask

    task automatic run_xfer(input string tag, input int n);
        logic [31:0] d;
        bit ok;
        clear_all();
        slave_reload();
        for (int i = 0; i < n; i++)
            bus_write(3'd5, 32'(((i == n - 1) ? 32'h100 : 32'h0) | 32'(txv(i))));
        bus_write(3'd1, 32'h4);
        wait_ev(0, ok);
        check_eq(tag, "done event", int'(ok), 1);
        repeat (6) @(negedge clk);
        check_eq(tag, "words seen by slave", cap_n, n);
        for (int i = 0; i < n; i++)
            check_eq(tag, "mosi word", int'(cap[i]), int'(txv(i) & wmask()));
        for (int i = 0; i < n; i++) begin
            bus_read(3'd5, d);
            check_eq(tag, "rx word", int'(d), int'(resp[i] & wmask()));
        end
        check_eq(tag, "sclk idle level", int'(sclk), b_cpol);
        check_eq("R1", "half period", last_half, 2 * (b_rate + 1));
    endtask

    task automatic test_reset();
        logic [31:0] d;
        bus_read(3'd2, d); check_eq("R6", "status reset", int'(d), 4);
        bus_read(3'd3, d); check_eq("R7", "event reset", int'(d), 0);
        bus_read(3'd4, d); check_eq("R12", "mask reset", int'(d), 32'h3F);
        check_eq("R12", "irq reset", int'(irq), 0);
        check_eq("R2", "sclk reset", int'(sclk), 0);
    endtask

    task automatic test_modes();
        logic [31:0] d;
        set_cfg(1, 0, 0, 0, 7, 0, 0);
        bus_read(3'd2, d); check_eq("R6", "ready after enable", int'(d[0]), 1);
        run_xfer("R4", 3);
        set_cfg(1, 1, 1, 2, 7, 0, 0);
        check_eq("R2", "cpol=1 idle high", int'(sclk), 1);
        run_xfer("R2", 2);
        set_cfg(1, 0, 1, 1, 7, 0, 0);
        run_xfer("R2", 2);
        set_cfg(1, 1, 0, 3, 7, 0, 0);
        run_xfer("R2", 2);
        set_cfg(1, 0, 0, 0, 3, 0, 0);
        run_xfer("R3", 3);
    endtask

    task automatic test_w1c_irq();
        logic [31:0] d;
        set_cfg(1, 0, 0, 0, 7, 0, 0);
        run_xfer("R4", 1);
        bus_write(3'd4, 32'h3E);
        @(negedge clk);
        check_eq("R12", "irq from unmasked done", int'(irq), 1);
        bus_read(3'd2, d); check_eq("R6", "status irq pending", int'(d[3]), 1);
        bus_write(3'd3, 32'h2);
        bus_read(3'd3, d); check_eq("R7", "done kept after writing other bit", int'(d[0]), 1);
        bus_write(3'd3, 32'h1);
        bus_read(3'd3, d); check_eq("R7", "done cleared by one", int'(d[0]), 0);
        check_eq("R12", "irq low after clear", int'(irq), 0);
        bus_write(3'd4, 32'h3F);
    endtask

    task automatic test_ctrl();
        logic [31:0] d;
        bit ok;
        bus_read(3'd1, d); check_eq("R5", "control reads zero", int'(d), 0);
        clear_all();
        bus_write(3'd5, 32'h1C3);
        bus_write(3'd1, 32'h4);
        wait_ev(0, ok);
        bus_read(3'd2, d); check_eq("R5", "rx has data", int'(d[2]), 0);
        bus_write(3'd1, 32'h1);
        bus_read(3'd2, d); check_eq("R5", "rx cleared", int'(d[2]), 1);
        set_cfg(0, 0, 0, 0, 7, 0, 0);
        clear_all();
        bus_write(3'd5, 32'h1AA);
        bus_write(3'd1, 32'h4);
        repeat (60) @(negedge clk);
        check_eq("R5", "start while disabled: no words", cap_n, 0);
        bus_read(3'd3, d); check_eq("R5", "start while disabled: no done", int'(d[0]), 0);
    endtask

    task automatic test_full();
        logic [31:0] d;
        bit ok;
        set_cfg(1, 0, 0, 0, 7, 0, 0);
        clear_all();
        slave_reload();
        for (int i = 0; i < 8; i++)
            bus_write(3'd5, 32'(((i == 7) ? 32'h100 : 32'h0) | 32'(txv(i))));
        bus_read(3'd2, d); check_eq("R6", "tx full status", int'(d[1]), 1);
        bus_write(3'd5, 32'h1EE);
        bus_write(3'd1, 32'h4);
        wait_ev(0, ok);
        repeat (80) @(negedge clk);
        check_eq("R13", "push when full ignored", cap_n, 8);
        bus_read(3'd5, d); check_eq("R13", "data read pops first word", int'(d), int'(resp[0]));
        bus_read(3'd5, d); check_eq("R13", "data read pops second word", int'(d), int'(resp[1]));
    endtask

    task automatic test_underflow();
        logic [31:0] d;
        bit ok;
        set_cfg(1, 0, 0, 0, 7, 0, 0);
        clear_all();
        slave_reload();
        bus_write(3'd5, 32'(txv(0)));
        bus_write(3'd5, 32'(txv(1)));
        bus_write(3'd1, 32'h4);
        wait_ev(2, ok);
        check_eq("R8", "underflow event", int'(ok), 1);
        repeat (20) @(negedge clk);
        check_eq("R8", "two words before pause", cap_n, 2);
        check_eq("R8", "clock idle while starved", int'(sclk), 0);
        bus_read(3'd3, d); check_eq("R8", "no done while starved", int'(d[0]), 0);
        bus_write(3'd5, 32'h100 | 32'(txv(2)));
        wait_ev(0, ok);
        repeat (6) @(negedge clk);
        check_eq("R8", "resumed word count", cap_n, 3);
        check_eq("R8", "resumed word", int'(cap[2]), int'(txv(2)));
    endtask

    task automatic test_overflow();
        logic [31:0] d;
        bit ok;
        set_cfg(1, 0, 0, 1, 7, 0, 0);
        clear_all();
        slave_reload();
        for (int i = 0; i < 8; i++) bus_write(3'd5, 32'(txv(i)));
        bus_write(3'd1, 32'h4);
        d = 32'h2;
        for (int k = 0; k < 200 && d[1]; k++) bus_read(3'd2, d);
        bus_write(3'd5, 32'h100 | 32'(txv(8)));
        wait_ev(0, ok);
        bus_read(3'd3, d); check_eq("R9", "overflow event", int'(d[1]), 1);
        for (int i = 0; i < 8; i++) begin
            bus_read(3'd5, d);
            check_eq("R9", "kept rx word", int'(d), int'(resp[i]));
        end
        bus_read(3'd2, d); check_eq("R9", "dropped ninth word", int'(d[2]), 1);
    endtask

    task automatic test_multimaster();
        logic [31:0] d;
        logic s0;
        set_cfg(1, 0, 0, 3, 7, 0, 0);
        clear_all();
        slave_reload();
        bus_write(3'd4, 32'h37);
        for (int i = 0; i < 4; i++)
            bus_write(3'd5, 32'(((i == 3) ? 32'h100 : 32'h0) | 32'(txv(i))));
        bus_write(3'd1, 32'h4);
        repeat (30) @(negedge clk);
        ss_in_n = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(3'd3, d); check_eq("R10", "multi-master event", int'(d[3]), 1);
        check_eq("R10", "irq from multi-master", int'(irq), 1);
        s0 = sclk;
        repeat (40) @(negedge clk);
        check_eq("R10", "sclk idle after abort", int'(sclk), 0);
        check_eq("R10", "sclk frozen after abort", int'(sclk), int'(s0));
        check_eq("R10", "no full word after abort", int'(cap_n < 1), 1);
        ss_in_n = 1'b1;
        bus_write(3'd4, 32'h3F);
        clear_all();
        bus_read(3'd3, d);
        check_eq("R10", "multi-master cleared", int'(d[3]), 0);
        check_eq("R10", "no done after abort", int'(d[0]), 0);
    endtask

    task automatic test_thresholds();
        logic [31:0] d;
        bit ok;
        set_cfg(1, 0, 0, 0, 7, 7, 1);
        clear_all();
        bus_write(3'd5, 32'h11);
        bus_write(3'd3, 32'h3F);
        bus_read(3'd3, d); check_eq("R11", "tx request off with 7 free", int'(d[4]), 0);
        bus_write(3'd1, 32'h2);
        bus_read(3'd3, d); check_eq("R11", "tx request on with 8 free", int'(d[4]), 1);
        bus_write(3'd5, 32'h122);
        bus_write(3'd1, 32'h4);
        wait_ev(0, ok);
        bus_read(3'd3, d); check_eq("R11", "rx request off at 1 entry", int'(d[5]), 0);
        bus_write(3'd3, 32'h3F);
        bus_write(3'd5, 32'h133);
        bus_write(3'd1, 32'h4);
        wait_ev(0, ok);
        bus_read(3'd3, d); check_eq("R11", "rx request on at 2 entries", int'(d[5]), 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) resp[i] = 8'(8'hC3 ^ (i * 53));
        for (int i = 0; i < 16; i++) cap[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_modes();
        test_w1c_irq();
        test_ctrl();
        test_full();
        test_underflow();
        test_overflow();
        test_multimaster();
        test_thresholds();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule